// File: doc/BRIEF.md
# Power Management Wake Status Logic

This block holds a 16-bit power-management status register whose bits are set by hardware events and cleared by software writing ones. It also turns enabled status events into a request to bring a sleeping system back on. Once the system is running, the same events become an SCI or an SMI interrupt, chosen by a routing select bit.

Four event sources set plain status bits. A PCI Express wake bit records that a WAKE# signal or a received PME message brought the system out of sleep. This bit is level-sensitive and cannot be cleared while its source is still active. A wake bit records that an enabled wake event ended a sleep. The wake bit is written only when the sleep was entered through the sleep-enable flag, or when it was armed by the recovery policy after a power failure. The wake bit survives a warm reset and is cleared only by the resume-well reset.

Top module: `pwr_wake_stat`

## Requirements
- R1: An active resume reset (`resumeRstN` low) clears the whole register to 0000h. An active warm reset (`warmRstN` low) clears bits 14:0 and keeps bit 15 unchanged.
- R2: A write with `wrEn` high clears each implemented bit whose `wrData` bit is 1, in the next clock. Data bits that are 0 change nothing. Bits 1-4, 6, 7, 9 and 11-13 always read 0 and ignore writes.
- R3: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R4: `evtPulse` and `evtEn` map to register bits as follows: index 0 is bit 0 (timer), index 1 is bit 5 (bus activity), index 2 is bit 8 (button), index 3 is bit 10 (alarm). A pulse sets its bit at the next clock.
- R5: `wakeReq` is high while `sleepState` is nonzero and either bit 8 with `evtEn[2]` or bit 10 with `evtEn[3]` is set. Bits 0, 5 and 14 never raise it.
- R6: With `sleepState` zero and bit 0, 8 or 10 set together with its enable, `sciOut` is high if `sciRoute` is 1 and `smiOut` is high if `sciRoute` is 0. Neither output is high while `sleepState` is nonzero.
- R7: Bit 5 with `evtEn[1]` raises `sciOut` when `sciRoute` is 1 and the system is in S0. It never raises `smiOut`.
- R8: Bit 15 is set at the clock after a cycle in which the system is asleep and an enabled bit-8/bit-10 wake is pending. This happens only when `slpEnFlag` is 1 or recovery arming is active.
- R9: Suppose power is lost (`pwrLost`) while `slpEnFlag` is 0 and `afterFailOff` is 0. Then `wakeReq` pulses for one cycle, starting at the clock after `pwrBack`, and bit 15 stays clear.
- R10: Suppose power is lost while `slpEnFlag` is 0 and `afterFailOff` is 1. Then no `wakeReq` follows `pwrBack`, and the next enabled wake while asleep sets bit 15 even with `slpEnFlag` 0. The arming ends once `sleepState` is zero.
- R11: Bit 14 is set at the clock that follows a cycle in which `sleepState` changes from nonzero to zero while `pcieWakeIn` or `pmeSeen` is high. An active source while the system stays in S0 does not set it.
- R12: A write-one clear of bit 14 has no effect while `pcieWakeIn` or `pmeSeen` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| resumeRstN | input | 1 | Resume-well synchronous reset, active low |
| warmRstN | input | 1 | Warm synchronous reset, active low |
| sleepState | input | STATE_W | Current system sleep state, 0 = running (S0) |
| slpEnFlag | input | 1 | Current sleep was entered through the sleep-enable flag |
| afterFailOff | input | 1 | Power-loss policy: 1 = stay off after power returns |
| pwrLost | input | 1 | One-cycle pulse: power failure |
| pwrBack | input | 1 | One-cycle pulse: power returned |
| evtPulse | input | 4 | Event set pulses (timer, bus, button, alarm) |
| evtEn | input | 4 | Per-event enables, same order as evtPulse |
| sciRoute | input | 1 | 1 = route events to SCI, 0 = to SMI |
| pcieWakeIn | input | 1 | PCI Express WAKE# active (level) |
| pmeSeen | input | 1 | PME message received and not yet cleared (level) |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Write data, ones clear bits |
| statusRd | output | 16 | Register readback |
| wakeReq | output | 1 | Request to move the system to ON |
| sciOut | output | 1 | SCI request (level) |
| smiOut | output | 1 | SMI request (level) |

## Verification
Two functions can land on the same clock: a hardware set and a software clear of one bit, and a software clear of bit 14 while its level source is still active. The vector table drives a timer pulse and a write of one to bit 0 in the same cycle. A directed test writes one to bit 14 while WAKE# is high, then while PME is high. In each case the readback one clock later must still show the bit set, and the same write issued after the sources drop must clear it.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  localparam int REG_W = 16;
  localparam int N_EVT = 4;

  // register positions of the pulse-set events, indexed like evtPulse/evtEn
  localparam int EVT_POS [N_EVT] = '{0, 5, 8, 10};
  localparam int IDX_TMR = 0;
  localparam int IDX_BUS = 1;
  localparam int IDX_BTN = 2;
  localparam int IDX_RTC = 3;

  localparam int POS_PCIE = 14;
  localparam int POS_WAKE = 15;

  localparam logic [REG_W-1:0] LIVE_MASK =
      (REG_W'(1) << EVT_POS[0]) | (REG_W'(1) << EVT_POS[1]) |
      (REG_W'(1) << EVT_POS[2]) | (REG_W'(1) << EVT_POS[3]) |
      (REG_W'(1) << POS_PCIE)   | (REG_W'(1) << POS_WAKE);
  localparam logic [REG_W-1:0] KEEP_MASK = REG_W'(1) << POS_WAKE;

  // control -> datapath strobes
  typedef struct packed {
    logic asleep;     // system is in a non-S0 state
    logic enterRun;   // this cycle is the first S0 cycle after sleep
    logic wakeArmed;  // a wake may be recorded in the wake bit
  } wakeStrobe_t;
endpackage

// File: rtl/pwr_wake_dp.sv
module pwr_wake_dp
  import pwr_wake_pkg::*;
(
  input  logic             clk,
  input  logic             resumeRstN,
  input  logic             warmRstN,
  input  wakeStrobe_t      strobe,
  input  logic [N_EVT-1:0] evtPulse,
  input  logic [N_EVT-1:0] evtEn,
  input  logic             pcieSrc,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] stsQ,
  output logic             wakeEvt,
  output logic             runPending,
  output logic             busPending
);
  logic [REG_W-1:0] setReq;
  logic [REG_W-1:0] clrEff;
  logic [REG_W-1:0] stsNext;
  logic [N_EVT-1:0] evtLive;

  // enabled event bits currently set
  always_comb begin
    for (int i = 0; i < N_EVT; i++) begin
      evtLive[i] = stsQ[EVT_POS[i]] & evtEn[i];
    end
  end

  assign wakeEvt    = evtLive[IDX_BTN] | evtLive[IDX_RTC];
  assign runPending = evtLive[IDX_TMR] | wakeEvt;
  assign busPending = evtLive[IDX_BUS];

  // hardware set requests
  always_comb begin
    setReq = '0;
    for (int i = 0; i < N_EVT; i++) begin
      setReq[EVT_POS[i]] = evtPulse[i];
    end
    setReq[POS_PCIE] = strobe.enterRun & pcieSrc;
    setReq[POS_WAKE] = strobe.asleep & strobe.wakeArmed & wakeEvt;
  end

  // software clear, bit 14 held while its level source is active
  always_comb begin
    clrEff = wrEn ? wrData : '0;
    clrEff[POS_PCIE] = wrEn & wrData[POS_PCIE] & ~pcieSrc;
  end

  // set has priority over clear
  assign stsNext = (setReq | (stsQ & ~clrEff)) & LIVE_MASK;

  always_ff @(posedge clk) begin
    if (!resumeRstN) begin
      stsQ <= '0;
    end else if (!warmRstN) begin
      stsQ <= stsQ & KEEP_MASK;
    end else begin
      stsQ <= stsNext;
    end
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int STATE_W = 3
) (
  input  logic               clk,
  input  logic               resumeRstN,
  input  logic [STATE_W-1:0] sleepState,
  input  logic               slpEnFlag,
  input  logic               afterFailOff,
  input  logic               pwrLost,
  input  logic               pwrBack,
  input  logic               sciRoute,
  input  logic               wakeEvt,
  input  logic               runPending,
  input  logic               busPending,
  output wakeStrobe_t        strobe,
  output logic               wakeReq,
  output logic               sciOut,
  output logic               smiOut
);
  logic asleep;
  logic prevAsleep;
  logic lossLatch;   // power lost without the sleep-enable flag
  logic recoverArm;  // stay-off recovery: next wake is recorded
  logic bootPulse;   // return-to-on after power comes back

  assign asleep = |sleepState;

  always_ff @(posedge clk) begin
    if (!resumeRstN) begin
      prevAsleep <= 1'b0;
      lossLatch  <= 1'b0;
      recoverArm <= 1'b0;
      bootPulse  <= 1'b0;
    end else begin
      prevAsleep <= asleep;
      bootPulse  <= pwrBack & lossLatch & ~afterFailOff;
      if (pwrLost && !slpEnFlag) begin
        lossLatch <= 1'b1;
      end else if (pwrBack) begin
        lossLatch <= 1'b0;
      end
      if (pwrBack && lossLatch && afterFailOff) begin
        recoverArm <= 1'b1;
      end else if (!asleep) begin
        recoverArm <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.asleep    = asleep;
    strobe.enterRun  = ~asleep & prevAsleep;
    strobe.wakeArmed = slpEnFlag | recoverArm;
  end

  assign wakeReq = (asleep & wakeEvt) | bootPulse;
  assign sciOut  = ~asleep & sciRoute & (runPending | busPending);
  assign smiOut  = ~asleep & ~sciRoute & runPending;
endmodule

// File: rtl/pwr_wake_stat.sv
module pwr_wake_stat
  import pwr_wake_pkg::*;
#(
  parameter int STATE_W = 3
) (
  input  logic               clk,
  input  logic               resumeRstN,
  input  logic               warmRstN,
  input  logic [STATE_W-1:0] sleepState,
  input  logic               slpEnFlag,
  input  logic               afterFailOff,
  input  logic               pwrLost,
  input  logic               pwrBack,
  input  logic [3:0]         evtPulse,
  input  logic [3:0]         evtEn,
  input  logic               sciRoute,
  input  logic               pcieWakeIn,
  input  logic               pmeSeen,
  input  logic               wrEn,
  input  logic [15:0]        wrData,
  output logic [15:0]        statusRd,
  output logic               wakeReq,
  output logic               sciOut,
  output logic               smiOut
);
  wakeStrobe_t strobe;
  logic        wakeEvt;
  logic        runPending;
  logic        busPending;
  logic        pcieSrc;

  assign pcieSrc = pcieWakeIn | pmeSeen;

  pwr_wake_ctrl #(.STATE_W(STATE_W)) u_ctrl (
    .clk         (clk),
    .resumeRstN  (resumeRstN),
    .sleepState  (sleepState),
    .slpEnFlag   (slpEnFlag),
    .afterFailOff(afterFailOff),
    .pwrLost     (pwrLost),
    .pwrBack     (pwrBack),
    .sciRoute    (sciRoute),
    .wakeEvt     (wakeEvt),
    .runPending  (runPending),
    .busPending  (busPending),
    .strobe      (strobe),
    .wakeReq     (wakeReq),
    .sciOut      (sciOut),
    .smiOut      (smiOut)
  );

  pwr_wake_dp u_dp (
    .clk       (clk),
    .resumeRstN(resumeRstN),
    .warmRstN  (warmRstN),
    .strobe    (strobe),
    .evtPulse  (evtPulse),
    .evtEn     (evtEn),
    .pcieSrc   (pcieSrc),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .stsQ      (statusRd),
    .wakeEvt   (wakeEvt),
    .runPending(runPending),
    .busPending(busPending)
  );
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk #(
  parameter int STATE_W = 3
) (
  input logic               clk,
  input logic               resumeRstN,
  input logic               warmRstN,
  input logic [STATE_W-1:0] sleepState,
  input logic               evtTmr,
  input logic               evtBtn,
  input logic               pcieWakeIn,
  input logic               pmeSeen,
  input logic               wrEn,
  input logic               wrClr0,
  input logic               wrClr14,
  input logic [15:0]        statusRd,
  input logic               sciOut,
  input logic               smiOut
);
  AST_WARM_CLEARS_LOW: assert property (@(posedge clk) disable iff (!resumeRstN)
    !warmRstN |=> statusRd[14:0] == 15'd0); // R1

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!resumeRstN)
    (warmRstN && wrEn && wrClr0 && !evtTmr) |=> !statusRd[0]); // R2

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!resumeRstN)
    (warmRstN && evtBtn) |=> statusRd[8]); // R3

  AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!resumeRstN)
    (sleepState != '0) |-> (!sciOut && !smiOut)); // R6

  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!resumeRstN)
    !(sciOut && smiOut)); // R6

  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!resumeRstN)
    $rose(statusRd[15]) |-> $past(sleepState != '0)); // R8

  AST_PCIE_ON_ENTRY: assert property (@(posedge clk) disable iff (!resumeRstN)
    $rose(statusRd[14]) |-> $past(sleepState == '0)); // R11

  AST_PCIE_HOLD: assert property (@(posedge clk) disable iff (!resumeRstN)
    (warmRstN && wrEn && wrClr14 && statusRd[14] && (pcieWakeIn || pmeSeen))
      |=> statusRd[14]); // R12
endmodule

bind pwr_wake_stat pwr_wake_chk #(.STATE_W(STATE_W)) u_chk (
  .clk       (clk),
  .resumeRstN(resumeRstN),
  .warmRstN  (warmRstN),
  .sleepState(sleepState),
  .evtTmr    (evtPulse[0]),
  .evtBtn    (evtPulse[2]),
  .pcieWakeIn(pcieWakeIn),
  .pmeSeen   (pmeSeen),
  .wrEn      (wrEn),
  .wrClr0    (wrData[0]),
  .wrClr14   (wrData[14]),
  .statusRd  (statusRd),
  .sciOut    (sciOut),
  .smiOut    (smiOut)
);

// File: tb/pwr_wake_stat_tb.sv
`timescale 1ns/1ps
module pwr_wake_stat_tb;
  localparam int STATE_W = 3;

  logic               clk = 1'b0;
  logic               resumeRstN = 1'b0;
  logic               warmRstN = 1'b0;
  logic [STATE_W-1:0] sleepState = '0;
  logic               slpEnFlag = 1'b0;
  logic               afterFailOff = 1'b0;
  logic               pwrLost = 1'b0;
  logic               pwrBack = 1'b0;
  logic [3:0]         evtPulse = '0;
  logic [3:0]         evtEn = '0;
  logic               sciRoute = 1'b0;
  logic               pcieWakeIn = 1'b0;
  logic               pmeSeen = 1'b0;
  logic               wrEn = 1'b0;
  logic [15:0]        wrData = '0;
  logic [15:0]        statusRd;
  logic               wakeReq;
  logic               sciOut;
  logic               smiOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_wake_stat #(.STATE_W(STATE_W)) u_dut (
    .clk(clk), .resumeRstN(resumeRstN), .warmRstN(warmRstN),
    .sleepState(sleepState), .slpEnFlag(slpEnFlag), .afterFailOff(afterFailOff),
    .pwrLost(pwrLost), .pwrBack(pwrBack), .evtPulse(evtPulse), .evtEn(evtEn),
    .sciRoute(sciRoute), .pcieWakeIn(pcieWakeIn), .pmeSeen(pmeSeen),
    .wrEn(wrEn), .wrData(wrData), .statusRd(statusRd), .wakeReq(wakeReq),
    .sciOut(sciOut), .smiOut(smiOut)
  );

  typedef struct packed {
    logic [3:0]  evt;
    logic [3:0]  en;
    logic        sci;
    logic        wr;
    logic [15:0] data;
    logic [15:0] expSts;
    logic        expSci;
    logic        expSmi;
  } vec_t;

  // all vectors run in S0; each is applied for one clock
  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{4'h1, 4'h0, 1'b1, 1'b0, 16'h0000, 16'h0001, 1'b0, 1'b0},
    '{4'h0, 4'h1, 1'b1, 1'b0, 16'h0000, 16'h0001, 1'b1, 1'b0},
    '{4'h0, 4'h1, 1'b0, 1'b0, 16'h0000, 16'h0001, 1'b0, 1'b1},
    '{4'h2, 4'h2, 1'b0, 1'b0, 16'h0000, 16'h0021, 1'b0, 1'b0},
    '{4'h0, 4'h2, 1'b1, 1'b0, 16'h0000, 16'h0021, 1'b1, 1'b0},
    '{4'h0, 4'h0, 1'b1, 1'b1, 16'h0000, 16'h0021, 1'b0, 1'b0},
    '{4'h0, 4'h0, 1'b1, 1'b1, 16'h0020, 16'h0001, 1'b0, 1'b0},
    '{4'h4, 4'h4, 1'b0, 1'b0, 16'h0000, 16'h0101, 1'b0, 1'b1},
    '{4'h8, 4'h8, 1'b1, 1'b1, 16'h0100, 16'h0401, 1'b1, 1'b0},
    '{4'h0, 4'h0, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
    '{4'h1, 4'h1, 1'b1, 1'b1, 16'h0001, 16'h0001, 1'b1, 1'b0},
    '{4'h0, 4'h0, 1'b1, 1'b1, 16'h3801, 16'h0000, 1'b0, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    wrEn = 1'b1; wrData = 16'hFFFF;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    resumeRstN = 1'b1; warmRstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 reset status", statusRd, 16'h0000);
    chk("R1 reset outputs", {13'd0, wakeReq, sciOut, smiOut}, 16'h0000);

    // R2 R3 R4 R6 R7 table
    for (int i = 0; i < NVEC; i++) begin
      evtPulse = VEC[i].evt; evtEn = VEC[i].en; sciRoute = VEC[i].sci;
      wrEn = VEC[i].wr; wrData = VEC[i].data;
      tick();
      evtPulse = '0; wrEn = 1'b0; wrData = '0;
      chk($sformatf("R2/R3/R4 vector %0d status", i), statusRd, VEC[i].expSts);
      chk($sformatf("R6/R7 vector %0d sci/smi", i), {14'd0, sciOut, smiOut},
          {14'd0, VEC[i].expSci, VEC[i].expSmi});
    end

    // R5 R8: sleep via flag, button wake
    sleepState = 3'd3; slpEnFlag = 1'b1; evtEn = 4'b0100; sciRoute = 1'b1;
    evtPulse = 4'b0100;
    tick();
    evtPulse = '0;
    chk("R4 button bit set", statusRd, 16'h0100);
    chk("R5 wakeReq asleep", {15'd0, wakeReq}, 16'h0001);
    chk("R6 no sci asleep", {14'd0, sciOut, smiOut}, 16'h0000);
    tick();
    chk("R8 wake bit set", statusRd, 16'h8100);
    sleepState = '0; slpEnFlag = 1'b0;
    tick();
    chk("R6 sci after return", {14'd0, sciOut, smiOut}, 16'h0002);
    // R1 warm keeps bit 15, resume clears all
    warmRstN = 1'b0;
    tick();
    warmRstN = 1'b1;
    chk("R1 warm reset keeps wake bit", statusRd, 16'h8000);
    resumeRstN = 1'b0;
    tick();
    resumeRstN = 1'b1;
    tick();
    chk("R1 resume reset clears", statusRd, 16'h0000);

    // R8 no flag -> wake bit not recorded
    sleepState = 3'd3; slpEnFlag = 1'b0; evtPulse = 4'b0100;
    tick();
    evtPulse = '0;
    chk("R5 wakeReq without flag", {15'd0, wakeReq}, 16'h0001);
    tick();
    chk("R8 wake bit stays clear", statusRd, 16'h0100);
    wrEn = 1'b1; wrData = 16'h0100;
    tick();
    wrEn = 1'b0; wrData = '0;
    chk("R5 wakeReq drops after clear", {15'd0, wakeReq}, 16'h0000);

    // R5 R7: timer and bus bits never wake
    evtEn = 4'b0011; evtPulse = 4'b0011;
    tick();
    evtPulse = '0;
    chk("R4 timer+bus bits", statusRd, 16'h0021);
    chk("R5 no wake from bits 0/5", {15'd0, wakeReq}, 16'h0000);
    sleepState = '0; sciRoute = 1'b0;
    #1;
    chk("R7 bus bit no SMI", {14'd0, sciOut, smiOut}, 16'h0001);
    sciRoute = 1'b1;
    #1;
    chk("R7 bus bit SCI", {14'd0, sciOut, smiOut}, 16'h0002);
    clearAll();
    evtEn = '0;

    // R11 R12 PCI Express wake bit
    sleepState = 3'd3;
    tick();
    sleepState = '0; pcieWakeIn = 1'b1;
    tick();
    chk("R11 pcie bit on entry", statusRd, 16'h4000);
    wrEn = 1'b1; wrData = 16'h4000;
    tick();
    chk("R12 clear held by WAKE", statusRd, 16'h4000);
    pcieWakeIn = 1'b0; pmeSeen = 1'b1;
    tick();
    chk("R12 clear held by PME", statusRd, 16'h4000);
    pmeSeen = 1'b0;
    tick();
    wrEn = 1'b0; wrData = '0;
    chk("R12 clear after release", statusRd, 16'h0000);
    pcieWakeIn = 1'b1;
    tick(); tick();
    chk("R11 no set while in S0", statusRd, 16'h0000);
    pcieWakeIn = 1'b0;
    sleepState = 3'd3;
    tick();
    sleepState = '0; pmeSeen = 1'b1;
    tick();
    pmeSeen = 1'b0;
    chk("R11 pme sets bit", statusRd, 16'h4000);
    evtEn = 4'hF; sleepState = 3'd3;
    tick();
    chk("R5 pcie bit no wake", {15'd0, wakeReq}, 16'h0000);
    clearAll();
    sleepState = '0; evtEn = '0;
    tick();

    // R9 power loss, return to on
    sleepState = 3'd5; slpEnFlag = 1'b0; afterFailOff = 1'b0; pwrLost = 1'b1;
    tick();
    pwrLost = 1'b0; pwrBack = 1'b1;
    tick();
    pwrBack = 1'b0;
    chk("R9 boot wakeReq", {15'd0, wakeReq}, 16'h0001);
    tick();
    chk("R9 boot pulse one cycle", {15'd0, wakeReq}, 16'h0000);
    sleepState = '0;
    tick(); tick();
    chk("R9 wake bit clear", statusRd, 16'h0000);

    // R10 power loss, stay off, next wake recorded
    sleepState = 3'd5; afterFailOff = 1'b1; pwrLost = 1'b1;
    tick();
    pwrLost = 1'b0; pwrBack = 1'b1;
    tick();
    pwrBack = 1'b0;
    chk("R10 no boot wakeReq", {15'd0, wakeReq}, 16'h0000);
    evtEn = 4'b0100; evtPulse = 4'b0100;
    tick();
    evtPulse = '0;
    tick();
    chk("R10 wake bit after stay-off", statusRd, 16'h8100);
    sleepState = '0;
    tick();
    wrEn = 1'b1; wrData = 16'h8100;
    tick();
    wrEn = 1'b0; wrData = '0;
    chk("R2 clear wake bit", statusRd, 16'h0000);
    sleepState = 3'd3; evtPulse = 4'b0100;
    tick();
    evtPulse = '0;
    tick();
    chk("R10 arming ended", statusRd, 16'h0100);
    clearAll();
    sleepState = '0;
    tick();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule